// File: doc/BRIEF.md
# Leaf PTE Translator with Contiguous-Page Support

This block sits behind a page-table walker. Once the walker has found a leaf entry, it hands over the 64-bit entry, the virtual address, the level at which the leaf was found, the number of levels in the current scheme, and the make-executable-readable flag. One cycle later the block returns a physical address, a fault flag and three permission bits (read, write, execute).

Entries may carry a contiguous-mapping flag in the top bit. That flag marks a naturally aligned power-of-two group of small pages. The group size is encoded in the trailing zeros of the page number. Only one group size is legal: sixteen 4 KiB pages. Any other size, a zero page number, or a flagged entry above the last walk level is reported as a fault. For a legal group, the low page-number bits are replaced by virtual page bits. For superpages, the virtual page bits below the superpage boundary are merged into the physical page number.

The default geometry is a 39-bit virtual address, 9 virtual page bits per level, and three levels. Level 2 is the last level, the one that maps 4 KiB pages.

Top module: `pte_leaf_xlate`

## Requirements
- R1: `result_valid` is `req_valid` delayed by exactly one clock. It is low from reset and stays high for exactly one cycle per request.
- R2: With flag bit 63 clear and the leaf at the last level (`walk_level + 1 == level_count`), `pa` equals entry bits [62:10] shifted left by 12, ORed with `va[11:0]`.
- R3: Entry bit 63 never appears in the physical page number. The page number is taken from bits [62:10] only.
- R4: For a leaf at a level above the last, the low `9 * (level_count - 1 - walk_level)` bits of `va[38:12]` are ORed into the physical page number.
- R5: With bit 63 set, a legal leaf has page-number bits [3:0] equal to 4'b1000 and is found at the last level. Its low four page-number bits are replaced by `va[15:12]`.
- R6: With bit 63 set and a page number of zero, `fault` is 1.
- R7: With bit 63 set and the leaf not at the last level, `fault` is 1.
- R8: With bit 63 set and a trailing-zero count of the page number other than 3 (group size other than 16 pages), `fault` is 1.
- R9: `perm_rd` = R (bit 1) OR (X (bit 3) AND `mxr`). `perm_wr` copies W (bit 2). `perm_ex` copies X.
- R10: Whenever `fault` is 1, `pa` and all three permission outputs are zero. An entry with bit 63 clear never faults.
- R11: Without `req_valid`, `pa`, `fault` and the permission outputs hold their last values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| pte | input | 64 | Leaf page-table entry |
| va | input | 39 | Virtual address |
| walk_level | input | 2 | Level at which the leaf was found (0 = root) |
| level_count | input | 2 | Number of levels in the walk |
| mxr | input | 1 | Make executable pages readable |
| result_valid | output | 1 | Result strobe, one cycle after request |
| fault | output | 1 | Illegal contiguous-page encoding |
| pa | output | 65 | Physical address |
| perm_rd | output | 1 | Read permitted |
| perm_wr | output | 1 | Write permitted |
| perm_ex | output | 1 | Execute permitted |

## Verification
A miscounted trailing-zero value or a wrong level comparison shows up as a wrong `fault` on the very result that follows the offending request. A bad merge mask shows up in the same cycle as wrong page-number bits in `pa`: either the low group bits or the bits below a superpage boundary. A result register that updates without a request shows up at the first idle cycle as a changed `pa`. The directed tests place a request at each of these points and compare the result cycle with values computed independently.

// File: rtl/pte_xlate_pkg.sv
`timescale 1ns/1ps
package pte_xlate_pkg;
  parameter int PTE_W      = 64;
  parameter int NAPOT_POS  = 63;
  parameter int PPN_SHIFT  = 10;
  parameter int PG_OFS     = 12;
  parameter int VA_W       = 39;
  parameter int LVL_VPN    = 9;
  parameter int MAX_LEVELS = 3;
  parameter int NAPOT_LOG2 = 4;
  parameter int BIT_R      = 1;
  parameter int BIT_W      = 2;
  parameter int BIT_X      = 3;

  localparam int PPN_W = NAPOT_POS - PPN_SHIFT;
  localparam int PA_W  = PPN_W + PG_OFS;
  localparam int VPN_W = VA_W - PG_OFS;
  localparam int LVL_W = $clog2(MAX_LEVELS + 1);
  localparam int CNT_W = $clog2(PPN_W + 2);

  typedef logic [PPN_W-1:0] ppn_t;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
  } perm_t;

  // index of the least significant set bit (0 when none)
  function automatic logic [CNT_W-1:0] lowest_one(input ppn_t v);
    logic [CNT_W-1:0] idx;
    idx = '0;
    for (int i = PPN_W - 1; i >= 0; i--) begin
      if (v[i]) idx = CNT_W'(i);
    end
    return idx;
  endfunction

  // mask with the n lowest bits set
  function automatic ppn_t low_mask(input int n);
    ppn_t m;
    for (int i = 0; i < PPN_W; i++) m[i] = (i < n);
    return m;
  endfunction
endpackage

// File: rtl/napot_check.sv
`timescale 1ns/1ps
module napot_check
  import pte_xlate_pkg::*;
(
  input  logic             napot,
  input  ppn_t             ppn,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] levels,
  output logic [CNT_W-1:0] size_k,
  output logic             zero_ppn,
  output logic             not_last,
  output logic             bad_size,
  output logic             nap_fault
);
  logic [CNT_W-1:0] tz;

  always_comb begin
    tz       = lowest_one(ppn);
    size_k   = napot ? tz + CNT_W'(1) : '0;
    zero_ppn = napot && (ppn == '0);
    not_last = napot && ((int'(level) + 1) != int'(levels));
    bad_size = (size_k != '0) && (size_k != CNT_W'(NAPOT_LOG2));
    nap_fault = zero_ppn || not_last || bad_size;
  end
endmodule

// File: rtl/ppn_merge.sv
`timescale 1ns/1ps
module ppn_merge
  import pte_xlate_pkg::*;
(
  input  ppn_t             ppn,
  input  logic [VPN_W-1:0] vpn,
  input  logic [CNT_W-1:0] size_k,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] levels,
  output ppn_t             ppn_out
);
  ppn_t vpn_ext;
  ppn_t grp_mask;
  ppn_t sup_mask;
  int   span;

  always_comb begin
    vpn_ext = PPN_W'(vpn);
    if ((int'(level) + 1) < int'(levels))
      span = LVL_VPN * (int'(levels) - 1 - int'(level));
    else
      span = 0;
    grp_mask = low_mask(int'(size_k));
    sup_mask = low_mask(span);
    ppn_out  = (ppn & ~grp_mask) | (vpn_ext & grp_mask) | (vpn_ext & sup_mask);
  end
endmodule

// File: rtl/perm_map.sv
`timescale 1ns/1ps
module perm_map
  import pte_xlate_pkg::*;
(
  input  logic  r_bit,
  input  logic  w_bit,
  input  logic  x_bit,
  input  logic  mxr,
  input  logic  fault,
  output perm_t perm
);
  always_comb begin
    perm.rd = !fault && (r_bit || (x_bit && mxr));
    perm.wr = !fault && w_bit;
    perm.ex = !fault && x_bit;
  end
endmodule

// File: rtl/pte_leaf_xlate.sv
`timescale 1ns/1ps
module pte_leaf_xlate
  import pte_xlate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [PTE_W-1:0] pte,
  input  logic [VA_W-1:0]  va,
  input  logic [LVL_W-1:0] walk_level,
  input  logic [LVL_W-1:0] level_count,
  input  logic             mxr,
  output logic             result_valid,
  output logic             fault,
  output logic [PA_W-1:0]  pa,
  output logic             perm_rd,
  output logic             perm_wr,
  output logic             perm_ex
);
  // named internal events
  ppn_t             raw_ppn;
  ppn_t             merged_ppn;
  logic             napot_flag;
  logic [CNT_W-1:0] size_k;
  logic             zero_ppn;
  logic             not_last;
  logic             bad_size;
  logic             nap_fault;
  perm_t            perm_n;
  perm_t            perm_q;
  logic             unused_pte_bits;

  assign napot_flag      = pte[NAPOT_POS];
  assign raw_ppn         = pte[NAPOT_POS-1:PPN_SHIFT];
  assign unused_pte_bits = ^{pte[PPN_SHIFT-1:BIT_X+1], pte[0]};

  napot_check u_check (
    .napot     (napot_flag),
    .ppn       (raw_ppn),
    .level     (walk_level),
    .levels    (level_count),
    .size_k    (size_k),
    .zero_ppn  (zero_ppn),
    .not_last  (not_last),
    .bad_size  (bad_size),
    .nap_fault (nap_fault)
  );

  ppn_merge u_merge (
    .ppn     (raw_ppn),
    .vpn     (va[VA_W-1:PG_OFS]),
    .size_k  (size_k),
    .level   (walk_level),
    .levels  (level_count),
    .ppn_out (merged_ppn)
  );

  perm_map u_perm (
    .r_bit (pte[BIT_R]),
    .w_bit (pte[BIT_W]),
    .x_bit (pte[BIT_X]),
    .mxr   (mxr),
    .fault (nap_fault),
    .perm  (perm_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_valid <= 1'b0;
      fault        <= 1'b0;
      pa           <= '0;
      perm_q       <= '0;
    end else begin
      result_valid <= req_valid;
      if (req_valid) begin
        fault  <= nap_fault;
        pa     <= nap_fault ? '0 : {merged_ppn, va[PG_OFS-1:0]};
        perm_q <= perm_n;
      end
    end
  end

  assign perm_rd = perm_q.rd;
  assign perm_wr = perm_q.wr;
  assign perm_ex = perm_q.ex;
endmodule

// File: rtl/pte_leaf_xlate_chk.sv
`timescale 1ns/1ps
module pte_leaf_xlate_chk
  import pte_xlate_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [PTE_W-1:0] pte,
  input logic [VA_W-1:0]  va,
  input logic [LVL_W-1:0] walk_level,
  input logic [LVL_W-1:0] level_count,
  input logic             mxr,
  input logic             result_valid,
  input logic             fault,
  input logic [PA_W-1:0]  pa,
  input logic             perm_rd,
  input logic             perm_wr,
  input logic             perm_ex,
  input logic             nap_fault
);
  localparam logic [NAPOT_LOG2-1:0] GRP_PAT = NAPOT_LOG2'(1 << (NAPOT_LOG2 - 1));

  p_valid_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> result_valid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !result_valid);
  p_page_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pte[NAPOT_POS]) |=> (pa[PG_OFS-1:0] == $past(va[PG_OFS-1:0])));
  p_zero_ppn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pte[NAPOT_POS] && (pte[NAPOT_POS-1:PPN_SHIFT] == '0)) |=> fault);
  p_not_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pte[NAPOT_POS] && ((int'(walk_level) + 1) != int'(level_count))) |=> fault);
  p_bad_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pte[NAPOT_POS] && (pte[PPN_SHIFT +: NAPOT_LOG2] != GRP_PAT)) |=> fault);
  p_perm_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pte[NAPOT_POS]) |=>
      (perm_rd == $past(pte[BIT_R] | (pte[BIT_X] & mxr))) &&
      (perm_wr == $past(pte[BIT_W])) && (perm_ex == $past(pte[BIT_X])));
  p_fault_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> ((pa == '0) && !perm_rd && !perm_wr && !perm_ex));
  p_fault_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (fault == $past(nap_fault)));
  p_no_fault_plain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pte[NAPOT_POS]) |=> !fault);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(pa) && $stable(fault) && $stable(perm_rd)));
endmodule

bind pte_leaf_xlate pte_leaf_xlate_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .pte          (pte),
  .va           (va),
  .walk_level   (walk_level),
  .level_count  (level_count),
  .mxr          (mxr),
  .result_valid (result_valid),
  .fault        (fault),
  .pa           (pa),
  .perm_rd      (perm_rd),
  .perm_wr      (perm_wr),
  .perm_ex      (perm_ex),
  .nap_fault    (nap_fault)
);

// File: tb/pte_leaf_xlate_tb_top.sv
`timescale 1ns/1ps
module pte_leaf_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] pte = '0;
  logic [38:0] va = '0;
  logic [1:0]  walk_level = 2'd2;
  logic [1:0]  level_count = 2'd3;
  logic        mxr = 1'b0;
  logic        result_valid;
  logic        fault;
  logic [64:0] pa;
  logic        perm_rd;
  logic        perm_wr;
  logic        perm_ex;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pte_leaf_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .pte(pte), .va(va),
    .walk_level(walk_level), .level_count(level_count), .mxr(mxr),
    .result_valid(result_valid), .fault(fault), .pa(pa),
    .perm_rd(perm_rd), .perm_wr(perm_wr), .perm_ex(perm_ex)
  );

  task automatic check(input string tag, input logic [64:0] got, input logic [64:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // independent reference model
  task automatic model(input logic [63:0] e, input logic [38:0] v, input int lvl,
                       input int lvls, input bit mx, output logic [64:0] epa,
                       output bit ef, output bit er, output bit ew, output bit ex);
    logic [63:0] ppn;
    logic [63:0] tmp;
    logic [63:0] vpn;
    logic [63:0] p;
    int tz;
    int k;
    int span;
    bit nap;
    tmp = e << 1;
    ppn = tmp >> 11;
    nap = e[63];
    k = 0;
    if (nap) begin
      tz = 0;
      tmp = ppn;
      if (tmp != 0)
        while (tmp % 2 == 0) begin tmp = tmp / 2; tz++; end
      k = tz + 1;
    end
    ef = nap && (ppn == 0 || lvl != lvls - 1 || k != 4);
    vpn = {25'd0, v} / 4096;
    span = (lvl < lvls - 1) ? 9 * (lvls - 1 - lvl) : 0;
    p = ppn;
    if (nap) p = (ppn - (ppn % (64'd1 << k))) + (vpn % (64'd1 << k));
    p = p | (vpn % (64'd1 << span));
    epa = ef ? 65'd0 : {p[52:0], v[11:0]};
    er = !ef && (e[1] || (e[3] && mx));
    ew = !ef && e[2];
    ex = !ef && e[3];
  endtask

  task automatic run_one(input string tag, input logic [63:0] e, input logic [38:0] v,
                         input int lvl, input int lvls, input bit mx);
    logic [64:0] epa;
    bit ef, er, ew, ex;
    model(e, v, lvl, lvls, mx, epa, ef, er, ew, ex);
    @(negedge clk);
    pte = e; va = v; walk_level = 2'(lvl); level_count = 2'(lvls); mxr = mx;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R1 valid"}, 65'(result_valid), 65'd1);
    check({tag, " pa"}, pa, epa);
    check({tag, " fault"}, 65'(fault), 65'(ef));
    check({tag, " perms R9"}, 65'({perm_rd, perm_wr, perm_ex}), 65'({er, ew, ex}));
  endtask

  task automatic t_reset();
    check("R1 reset valid", 65'(result_valid), 65'd0);
    check("R1 reset pa", pa, 65'd0);
    check("R1 reset fault", 65'(fault), 65'd0);
  endtask

  task automatic t_plain();
    run_one("R2 plain a", 64'h0000_1234_5678_9C00, 39'h12_3456_7ABC, 2, 3, 0);
    run_one("R2 plain b", 64'h003F_FFFF_FFFF_FC0F, 39'h7F_FFFF_FFFF, 2, 3, 1);
    run_one("R2 plain c", 64'h0000_0000_0000_0402, 39'h00_0000_0001, 2, 3, 0);
  endtask

  task automatic t_super();
    run_one("R4 mega", 64'h0000_0000_2000_0006, 39'h00_ABCD_E123, 1, 3, 0);
    run_one("R4 giga", 64'h0000_0040_0000_000A, 39'h55_5555_5555, 0, 3, 0);
    run_one("R4 two-level", 64'h0000_0000_0800_0002, 39'h00_0FF0_0777, 0, 2, 0);
  endtask

  task automatic t_napot_ok();
    run_one("R5 R3 group a", 64'h8000_0000_0001_2002, 39'h00_0000_F123, 2, 3, 0);
    run_one("R5 R3 group b", 64'h8000_0ABC_DEF0_200E, 39'h12_3450_5FFF, 2, 3, 1);
    check("R3 top bit absent", 65'(pa[64]), 65'd0);
  endtask

  task automatic t_napot_bad();
    run_one("R6 zero ppn", 64'h8000_0000_0000_000E, 39'h00_0000_1234, 2, 3, 1);
    run_one("R7 not last", 64'h8000_0000_0001_2002, 39'h00_0000_1234, 1, 3, 0);
    run_one("R8 k3", 64'h8000_0000_0001_1002, 39'h00_0000_1234, 2, 3, 0);
    run_one("R8 k1", 64'h8000_0000_0001_0402, 39'h00_0000_1234, 2, 3, 0);
    run_one("R8 k5 R10", 64'h8000_0000_0001_4006, 39'h00_0000_1234, 2, 3, 0);
  endtask

  task automatic t_perm();
    for (int m = 0; m < 16; m++) begin
      logic [63:0] e;
      e = 64'h0000_0000_0003_0000 | 64'({m[2:0], 1'b1});
      run_one("R9 combo", e, 39'h00_0000_0ABC, 2, 3, m[3]);
    end
  endtask

  task automatic t_hold();
    logic [64:0] keep;
    run_one("R11 setup", 64'h0000_0000_0777_0006, 39'h00_0001_0456, 2, 3, 0);
    keep = pa;
    pte = 64'h8000_0000_0000_0000; va = '1; walk_level = 2'd0; mxr = 1'b1;
    @(negedge clk);
    check("R1 single pulse", 65'(result_valid), 65'd0);
    @(negedge clk);
    check("R11 pa hold", pa, keep);
    check("R11 fault hold", 65'(fault), 65'd0);
    check("R11 perm hold", 65'({perm_rd, perm_wr, perm_ex}), 65'b110);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_super();
    t_napot_ok();
    t_napot_bad();
    t_perm();
    t_hold();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired got=hang exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule